// File: doc/BRIEF.md
# Saturating 64-by-32 Integer Divider

This unit divides a 64-bit dividend by a 32-bit divisor for a 32-bit processor datapath. The dividend is built from a separate high-word register placed above operand A. The divisor is operand B. The unit works in unsigned or two's-complement signed mode. The quotient truncates toward zero. A quotient that does not fit in 32 bits is clamped to the nearest 32-bit limit, and an overflow flag is raised; the quotient never wraps.

A one-cycle `start` pulse latches the operands and the mode. The unit then develops one quotient bit per cycle on magnitudes, using a restoring shift-subtract loop, and applies the sign at the end. It answers with a one-cycle `done` pulse. A zero divisor skips the loop: the unit reports a trap in the cycle after `start` and leaves the previous result in place.

The caller can ask for a flag update with each operation. The unit then presents negative, zero, overflow and carry flags and pulses a write strobe to the flag logic.

Top module: `satdiv_unit`

## Requirements
- R1: In unsigned mode the dividend is {hi_word, op_a} and the divisor is op_b. When the quotient fits in 32 bits, `quotient` holds it exactly and `ovf` is 0.
- R2: In unsigned mode a quotient above 0xFFFFFFFF gives `quotient` = 0xFFFFFFFF and `ovf` = 1.
- R3: In signed mode both operands are two's complement and the quotient truncates toward zero. A quotient in [-2^31, 2^31-1] is returned exactly, with `ovf` = 0.
- R4: In signed mode a quotient above 2^31-1 clamps to 0x7FFFFFFF, and one below -2^31 clamps to 0x80000000. In both cases `ovf` = 1.
- R5: In signed mode the dividend 0x8000000000000000 divided by 0xFFFFFFFF (-1) gives 0x7FFFFFFF with `ovf` = 1.
- R6: A zero divisor raises `dz_trap` and `done` together in the first cycle after the accepting edge. `busy` stays 0, `quotient` and `ovf` keep their previous values, and `cc_we` stays 0.
- R7: For a non-zero divisor, `busy` is 1 from the cycle after the accepting edge until `done` rises. `done` is a single-cycle pulse, visible after the 65th rising edge following the accepting edge (2*DW+1), and `busy` is 0 while `done` is 1.
- R8: A `start` raised while `busy` is 1 is ignored. The operation in flight completes with its own operands and result.
- R9: With `cc_en` = 1 at start, `cc_we` pulses together with `done`, and `cc_flags` = {N = quotient[31], Z = (quotient == 0), V = ovf, C = 0}, bit 3 down to bit 0. With `cc_en` = 0, `cc_we` stays 0.
- R10: After reset, `busy`, `done`, `dz_trap`, `quotient`, `ovf`, `cc_we` and `cc_flags` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| signed_mode | input | 1 | 1 = signed, 0 = unsigned |
| cc_en | input | 1 | Request a condition-flag update |
| hi_word | input | DW | Upper half of the dividend |
| op_a | input | DW | Lower half of the dividend |
| op_b | input | DW | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| dz_trap | output | 1 | Divide-by-zero trap, coincides with done |
| quotient | output | DW | Saturated quotient, held until the next result |
| ovf | output | 1 | Quotient was clamped |
| cc_we | output | 1 | Write strobe for the flag logic |
| cc_flags | output | 4 | {N, Z, V, C} |

## Verification
The loop keeps its partial remainder and partial quotient in one shifting register, so a single wrong subtract decision corrupts every lower quotient bit. That error appears at `quotient` 65 cycles after start, when `done` pulses. A miscounted step counter moves the `done` pulse away from its fixed latency, so the bench measures latency on every operation. A sign or saturation fault only shows for certain operand signs and magnitudes. Random operands are therefore mixed with dividends that are sign-extended, near the limits, and with divisors of -1, 1 and 0.

// File: rtl/satdiv_unit.sv
module satdiv_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          signed_mode,
  input  logic          cc_en,
  input  logic [DW-1:0] hi_word,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          busy,
  output logic          done,
  output logic          dz_trap,
  output logic [DW-1:0] quotient,
  output logic          ovf,
  output logic          cc_we,
  output logic [3:0]    cc_flags
);

  localparam int NW = 2 * DW;
  localparam int CW = $clog2(NW);
  localparam logic [DW-1:0] UMAX = '1;
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [1:0] {IDLE, RUN, FIN} st_t;

  st_t           st;
  logic [NW-1:0] nq;
  logic [DW-1:0] rem;
  logic [DW-1:0] dmag;
  logic [CW-1:0] cnt;
  logic          neg_q, sg_q, cc_q;

  wire [NW-1:0] dvd     = {hi_word, op_a};
  wire          dvd_neg = signed_mode & dvd[NW-1];
  wire          dvs_neg = signed_mode & op_b[DW-1];
  wire [NW-1:0] dvd_mag = dvd_neg ? -dvd : dvd;
  wire [DW-1:0] dvs_mag = dvs_neg ? -op_b : op_b;

  wire [DW:0]   rem_sh  = {rem, nq[NW-1]};
  wire          take    = rem_sh >= {1'b0, dmag};

  wire hi_nz   = |nq[NW-1:DW];
  wire pos_big = hi_nz | nq[DW-1];
  wire neg_big = hi_nz | (nq[DW-1] & (|nq[DW-2:0]));

  logic [DW-1:0] res;
  logic          sat;

  always_comb begin
    if (!sg_q) begin
      sat = hi_nz;
      res = sat ? UMAX : nq[DW-1:0];
    end else if (!neg_q) begin
      sat = pos_big;
      res = sat ? SMAX : nq[DW-1:0];
    end else begin
      sat = neg_big;
      res = sat ? SMIN : -nq[DW-1:0];
    end
  end

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      nq       <= '0;
      rem      <= '0;
      dmag     <= '0;
      cnt      <= '0;
      neg_q    <= 1'b0;
      sg_q     <= 1'b0;
      cc_q     <= 1'b0;
      done     <= 1'b0;
      dz_trap  <= 1'b0;
      quotient <= '0;
      ovf      <= 1'b0;
      cc_we    <= 1'b0;
      cc_flags <= '0;
    end else begin
      done    <= 1'b0;
      dz_trap <= 1'b0;
      cc_we   <= 1'b0;
      case (st)
        IDLE: if (start) begin
          sg_q <= signed_mode;
          cc_q <= cc_en;
          if (op_b == '0) begin
            done    <= 1'b1;
            dz_trap <= 1'b1;
          end else begin
            nq    <= dvd_mag;
            dmag  <= dvs_mag;
            rem   <= '0;
            cnt   <= '0;
            neg_q <= dvd_neg ^ dvs_neg;
            st    <= RUN;
          end
        end
        RUN: begin
          rem <= take ? DW'(rem_sh - {1'b0, dmag}) : rem_sh[DW-1:0];
          nq  <= {nq[NW-2:0], take};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NW-1)) st <= FIN;
        end
        FIN: begin
          quotient <= res;
          ovf      <= sat;
          done     <= 1'b1;
          cc_we    <= cc_q;
          cc_flags <= {res[DW-1], res == '0, sat, 1'b0};
          st       <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_trap_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap |-> done && !cc_we);
  assert_trap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dz_trap |-> $stable(quotient) && $stable(ovf));
  assert_cc_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cc_we |-> done && !cc_flags[0] && (cc_flags[1] == ovf) && (cc_flags[3] == quotient[DW-1]));
  assert_usat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && !sg_q && ovf) |-> quotient == UMAX);
  assert_ssat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dz_trap && sg_q && ovf) |-> (quotient == SMAX || quotient == SMIN));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

endmodule

// File: tb/satdiv_unit_tb.sv
`timescale 1ns/1ps
module satdiv_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, signed_mode = 1'b0, cc_en = 1'b0;
  logic [31:0] hi_word = '0, op_a = '0, op_b = '0;
  logic busy, done, dz_trap, ovf, cc_we;
  logic [31:0] quotient;
  logic [3:0] cc_flags;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] prev_q = '0;
  logic prev_ovf = 1'b0;

  always #2 clk = ~clk;

  satdiv_unit #(.DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode), .cc_en(cc_en),
    .hi_word(hi_word), .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .dz_trap(dz_trap), .quotient(quotient), .ovf(ovf), .cc_we(cc_we), .cc_flags(cc_flags));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [32:0] model(input bit sg, input logic [31:0] y,
                                        input logic [31:0] a, input logic [31:0] b);
    logic [63:0] uq;
    longint n, d, q;
    if (!sg) begin
      uq = {y, a} / {32'b0, b};
      if (uq > 64'hFFFF_FFFF) return {1'b1, 32'hFFFF_FFFF};
      return {1'b0, uq[31:0]};
    end
    n = longint'({y, a});
    d = longint'($signed(b));
    if (n == 64'sh8000_0000_0000_0000 && d == -1) return {1'b1, 32'h7FFF_FFFF};
    q = n / d;
    if (q > 64'sd2147483647) return {1'b1, 32'h7FFF_FFFF};
    if (q < -64'sd2147483648) return {1'b1, 32'h8000_0000};
    return {1'b0, q[31:0]};
  endfunction

  task automatic run_op(input bit sg, input bit cc, input logic [31:0] y,
                        input logic [31:0] a, input logic [31:0] b, input bit poke);
    logic [32:0] exp;
    string tag;
    int e;
    bit gap;
    exp = model(sg, y, a, b);
    if (b == 0) tag = "R6";
    else if (exp[32]) tag = !sg ? "R2" : ({y, a} == 64'h8000_0000_0000_0000 && b == '1) ? "R5" : "R4";
    else tag = sg ? "R3" : "R1";
    @(negedge clk);
    signed_mode = sg; cc_en = cc; hi_word = y; op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e = 0; gap = 1'b0;
    while (!done && e < 100) begin
      if (!busy) gap = 1'b1;
      if (poke && e == 10) begin
        start = 1'b1; signed_mode = ~sg; hi_word = ~y; op_a = ~a; op_b = b + 32'd3;
      end else start = 1'b0;
      @(negedge clk);
      e++;
    end
    start = 1'b0;
    if (b == 0) begin
      chk(e == 0 && dz_trap && !busy, "R6", "trap timing", {32'(e), 31'b0, dz_trap}, 64'h1);
      chk(quotient == prev_q && ovf == prev_ovf, "R6", "result held", {ovf, quotient}, {prev_ovf, prev_q});
      chk(!cc_we, "R6", "no flag write", cc_we, 0);
    end else begin
      chk(e == 65 && !gap, poke ? "R8" : "R7", "latency", e, 65);
      chk(!dz_trap, "R7", "no trap", dz_trap, 0);
      chk({ovf, quotient} == exp, poke ? "R8" : tag, "result", {ovf, quotient}, exp);
      if (cc) chk(cc_we && cc_flags == {exp[31], exp[31:0] == 0, exp[32], 1'b0}, "R9", "flags",
                  {cc_we, cc_flags}, {1'b1, exp[31], exp[31:0] == 0, exp[32], 1'b0});
      else chk(!cc_we, "R9", "no flag write", cc_we, 0);
      prev_q = exp[31:0]; prev_ovf = exp[32];
    end
    @(negedge clk);
    chk(!done, "R7", "single done", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] y, a, b;
    bit sg;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dz_trap && !ovf && !cc_we && quotient == 0 && cc_flags == 0,
        "R10", "reset outputs", {busy, done, dz_trap, ovf, cc_we, cc_flags, quotient}, 0);
    rst_n = 1'b1;
    run_op(0, 1, 32'h0, 32'd100, 32'd7, 0);                       // R1
    run_op(0, 1, 32'h1, 32'h0, 32'h1, 0);                         // R2
    run_op(0, 0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0); // R1 max fit
    run_op(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 0);         // R3 -100/7
    run_op(1, 1, 32'h0, 32'h8000_0000, 32'hFFFF_FFFF, 0);         // R3 -> 0x80000000 fits
    run_op(1, 1, 32'h0, 32'h8000_0000, 32'h1, 0);                 // R4 positive clamp
    run_op(1, 1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h1, 0);         // R4 negative clamp
    run_op(1, 1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 0);         // R5
    run_op(1, 1, 32'h0, 32'd5, 32'd9, 0);                         // R9 zero flag
    run_op(0, 1, 32'h0, 32'd1, 32'h0, 0);                         // R6
    run_op(1, 0, 32'h0, 32'd999, 32'd3, 1);                       // R8
    for (int i = 0; i < 60; i++) begin
      sg = $urandom() % 2;
      a = $urandom();
      case ($urandom() % 4)
        0: y = 32'h0;
        1: y = $urandom() % 16;
        2: y = $urandom();
        default: y = {32{a[31]}};
      endcase
      case ($urandom() % 5)
        0: b = $urandom() % 8;
        1: b = -($urandom() % 8);
        default: b = $urandom();
      endcase
      run_op(sg, $urandom() % 2, y, a, b, ($urandom() % 8) == 0);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule